// File: doc/BRIEF.md
# Neighbour Sorter with Median Extraction

This block takes one filter window per cycle, either 3x3 or 5x5 pixels. The centre pixel arrives on its own port and the surrounding pixels arrive on a flat bus of 24 lanes. Only the surrounding pixels go through a pipelined compare-swap network, which sorts them in ascending order. The smallest neighbour, the largest neighbour and the median of the whole window are all read from that one sorted list. The centre pixel is folded in only at the last stage, by clamping it between the two middle sorted neighbours. The block therefore needs no separate minimum or maximum logic.

The window size is a per-sample tag that travels down the pipeline with its data, so 3x3 and 5x5 windows can be mixed on consecutive cycles. In 3x3 mode the upper 16 lanes are replaced inside the block by the largest pixel value. The network stages that exist only for the 5x5 case are then held in pass-through. A noise detector downstream uses the minimum or maximum to form its threshold and takes the median as the value to substitute.

Top module: `nbr_sort_median`

## Requirements
- R1: `min_o` is the smallest neighbour of the window: lanes 0..7 in 3x3 mode, lanes 0..23 in 5x5 mode. Lane k is `nbr_i[8k+7:8k]`.
- R2: `max_o` is the largest neighbour: the largest of lanes 0..7 in 3x3 mode (`win5_i`=0) and the largest of lanes 0..23 in 5x5 mode (`win5_i`=1).
- R3: In 3x3 mode, lanes 8..23 are ignored. Changing their values does not change `min_o`, `max_o` or `med_o`.
- R4: In 3x3 mode, `med_o` is the 5th smallest of the 9 values formed by lanes 0..7 plus `centre_i`.
- R5: In 5x5 mode, `med_o` is the 13th smallest of the 25 values formed by lanes 0..23 plus `centre_i`.
- R6: The centre pixel never sets `min_o` or `max_o`, even when it is more extreme than every neighbour.
- R7: A sample accepted on a rising edge with `valid_i`=1 produces `valid_o`=1 and its results 24 edges later. Counting the accepting edge as the first, this is a latency of 25 cycles. A new sample may be accepted every cycle, and `valid_o` is low when no sample is due.
- R8: While `rst_ni` is low, `valid_o`, `win5_o`, `min_o`, `max_o` and `med_o` are all 0.
- R9: `win5_o` returns the `win5_i` of the sample being output. Samples of different sizes may alternate cycle by cycle without affecting one another.
- R10: Windows whose values are all equal, including 0 and 255, give `min_o` = `max_o` = `med_o` = that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A window is present on the inputs |
| win5_i | input | 1 | Window size: 1 = 5x5, 0 = 3x3 |
| centre_i | input | 8 | Centre pixel of the window |
| nbr_i | input | 192 | 24 neighbour lanes of 8 bits, lane k at bits 8k+7:8k |
| valid_o | output | 1 | Results are valid |
| win5_o | output | 1 | Window size of the sample being output |
| min_o | output | 8 | Smallest neighbour |
| max_o | output | 8 | Largest neighbour |
| med_o | output | 8 | Median of neighbours and centre |

## Verification
The hardest case to reach is a 5x5-only stage passing a 3x3 sample through while the neighbouring stages hold a 5x5 sample. That only happens when window sizes alternate every cycle, so the bench streams back-to-back samples of alternating size and checks each result against its own tag. It also drives a 3x3 window whose ignored upper lanes carry zeros and random values. If those lanes leaked into the sort, the minimum would move. A centre pixel more extreme than every neighbour shows whether the centre ever reaches the minimum or maximum.

// File: rtl/nsm_pkg.sv
package nsm_pkg;
  typedef enum logic {
    WIN_SMALL = 1'b0,
    WIN_BIG   = 1'b1
  } win_e;
endpackage

// File: rtl/nsm_cs_cell.sv
module nsm_cs_cell #(
  parameter int DW = 8
) (
  input  logic          en_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] hi_o
);
  logic swap;
  assign swap = en_i && (a_i > b_i);
  assign hi_o = swap ? a_i : b_i;
  assign lo_o = swap ? b_i : a_i;
endmodule

// File: rtl/nsm_delay.sv
module nsm_delay #(
  parameter int W     = 9,
  parameter int DEPTH = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] sr [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
    end else begin
      sr[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
    end
  end

  assign q_o = sr[DEPTH-1];
endmodule

// File: rtl/nsm_sort_net.sv
// Odd-even transposition network, ascending (lane 0 smallest).
module nsm_sort_net #(
  parameter int DW        = 8,
  parameter int N_BIG     = 24,
  parameter int N_SMALL   = 8,
  parameter int REG_EVERY = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win5_i,
  input  logic [N_BIG*DW-1:0] lanes_i,
  output logic              win5_o,
  output logic [N_BIG*DW-1:0] lanes_o
);
  localparam int NSTAGE = N_BIG;

  logic [NSTAGE:0][N_BIG*DW-1:0] bus;
  logic [NSTAGE:0]               mode_bus;

  assign bus[0]      = lanes_i;
  assign mode_bus[0] = win5_i;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    localparam int OFF = s % 2;
    logic [N_BIG*DW-1:0] nxt;
    logic                en;

    // stages past N_SMALL only matter for the large window
    if (s < N_SMALL) begin : g_always
      assign en = 1'b1;
    end else begin : g_gated
      assign en = mode_bus[s];
    end

    for (genvar l = 0; l < N_BIG; l++) begin : g_lane
      if (l >= OFF && ((l - OFF) % 2) == 0 && (l + 1) < N_BIG) begin : g_cell
        nsm_cs_cell #(.DW(DW)) u_cs (
          .en_i (en),
          .a_i  (bus[s][l*DW +: DW]),
          .b_i  (bus[s][(l+1)*DW +: DW]),
          .lo_o (nxt[l*DW +: DW]),
          .hi_o (nxt[(l+1)*DW +: DW])
        );
      end else if (l >= OFF + 1 && ((l - OFF) % 2) == 1) begin : g_upper
        // driven by the cell of lane l-1
      end else begin : g_pass
        assign nxt[l*DW +: DW] = bus[s][l*DW +: DW];
      end
    end

    if (((s + 1) % REG_EVERY) == 0) begin : g_reg
      logic [N_BIG*DW-1:0] q;
      logic                mq;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q  <= '0;
          mq <= 1'b0;
        end else begin
          q  <= nxt;
          mq <= mode_bus[s];
        end
      end
      assign bus[s+1]      = q;
      assign mode_bus[s+1] = mq;
    end else begin : g_comb
      assign bus[s+1]      = nxt;
      assign mode_bus[s+1] = mode_bus[s];
    end
  end

  assign lanes_o = bus[NSTAGE];
  assign win5_o  = mode_bus[NSTAGE];
endmodule

// File: rtl/nsm_median_sel.sv
module nsm_median_sel #(
  parameter int DW      = 8,
  parameter int N_BIG   = 24,
  parameter int N_SMALL = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                win5_i,
  input  logic [DW-1:0]       centre_i,
  input  logic [N_BIG*DW-1:0] srt_i,
  output logic                valid_o,
  output logic                win5_o,
  output logic [DW-1:0]       min_o,
  output logic [DW-1:0]       max_o,
  output logic [DW-1:0]       med_o
);
  import nsm_pkg::*;

  localparam int LO_S = N_SMALL/2 - 1;
  localparam int HI_S = N_SMALL/2;
  localparam int LO_B = N_BIG/2 - 1;
  localparam int HI_B = N_BIG/2;

  win_e          win;
  logic [DW-1:0] lo, hi, mx, med;

  assign win = win_e'(win5_i);
  assign lo  = (win == WIN_BIG) ? srt_i[LO_B*DW +: DW] : srt_i[LO_S*DW +: DW];
  assign hi  = (win == WIN_BIG) ? srt_i[HI_B*DW +: DW] : srt_i[HI_S*DW +: DW];
  assign mx  = (win == WIN_BIG) ? srt_i[(N_BIG-1)*DW +: DW]
                                : srt_i[(N_SMALL-1)*DW +: DW];

  // centre clamped into the two middle neighbours gives the window median
  always_comb begin
    if (centre_i < lo)      med = lo;
    else if (centre_i > hi) med = hi;
    else                    med = centre_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      win5_o  <= 1'b0;
      min_o   <= '0;
      max_o   <= '0;
      med_o   <= '0;
    end else begin
      valid_o <= valid_i;
      win5_o  <= win5_i;
      min_o   <= srt_i[DW-1:0];
      max_o   <= mx;
      med_o   <= med;
    end
  end
endmodule

// File: rtl/nbr_sort_median.sv
module nbr_sort_median #(
  parameter int DW        = 8,
  parameter int N_BIG     = 24,
  parameter int N_SMALL   = 8,
  parameter int REG_EVERY = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                win5_i,
  input  logic [DW-1:0]       centre_i,
  input  logic [N_BIG*DW-1:0] nbr_i,
  output logic                valid_o,
  output logic                win5_o,
  output logic [DW-1:0]       min_o,
  output logic [DW-1:0]       max_o,
  output logic [DW-1:0]       med_o
);
  localparam int LAT_NET = N_BIG / REG_EVERY;
  localparam int LAT     = LAT_NET + 1;

  logic [N_BIG*DW-1:0] lanes_in;
  logic [N_BIG*DW-1:0] srt_w;
  logic                win5_net;
  logic                vld_net_w;
  logic [DW-1:0]       ctr_net;

  // small window: park unused lanes at full scale so they sort to the top
  for (genvar k = 0; k < N_BIG; k++) begin : g_mask
    if (k < N_SMALL) begin : g_keep
      assign lanes_in[k*DW +: DW] = nbr_i[k*DW +: DW];
    end else begin : g_fill
      assign lanes_in[k*DW +: DW] = win5_i ? nbr_i[k*DW +: DW] : {DW{1'b1}};
    end
  end

  nsm_sort_net #(
    .DW(DW), .N_BIG(N_BIG), .N_SMALL(N_SMALL), .REG_EVERY(REG_EVERY)
  ) u_net (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .win5_i  (win5_i),
    .lanes_i (lanes_in),
    .win5_o  (win5_net),
    .lanes_o (srt_w)
  );

  nsm_delay #(.W(DW+1), .DEPTH(LAT_NET)) u_side (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({valid_i, centre_i}),
    .q_o    ({vld_net_w, ctr_net})
  );

  nsm_median_sel #(.DW(DW), .N_BIG(N_BIG), .N_SMALL(N_SMALL)) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (vld_net_w),
    .win5_i   (win5_net),
    .centre_i (ctr_net),
    .srt_i    (srt_w),
    .valid_o  (valid_o),
    .win5_o   (win5_o),
    .min_o    (min_o),
    .max_o    (max_o),
    .med_o    (med_o)
  );
endmodule

// File: rtl/nsm_checker.sv
module nsm_checker #(
  parameter int DW    = 8,
  parameter int N_BIG = 24,
  parameter int LAT   = 25
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic                valid_o,
  input logic [DW-1:0]       min_o,
  input logic [DW-1:0]       max_o,
  input logic [DW-1:0]       med_o,
  input logic                srt_vld_i,
  input logic [N_BIG*DW-1:0] srt_i
);
  localparam int CW = $clog2(LAT + 1) + 1;
  logic [CW-1:0] inflight;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight <= '0;
    else inflight <= inflight + CW'(valid_i) - CW'(valid_o);
  end

  for (genvar k = 0; k < N_BIG - 1; k++) begin : g_asc
    assert_sorted_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srt_vld_i |-> (srt_i[k*DW +: DW] <= srt_i[(k+1)*DW +: DW]));
  end

  assert_med_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (min_o <= med_o && med_o <= max_o));

  assert_out_follows_in_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (inflight != '0));

  assert_inflight_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight <= CW'(LAT));
endmodule

bind nbr_sort_median nsm_checker #(.DW(DW), .N_BIG(N_BIG), .LAT(LAT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .valid_o   (valid_o),
  .min_o     (min_o),
  .max_o     (max_o),
  .med_o     (med_o),
  .srt_vld_i (vld_net_w),
  .srt_i     (srt_w)
);

// File: tb/nbr_sort_median_tb.sv
`timescale 1ns/1ps
module nbr_sort_median_tb;
  localparam int DW  = 8;
  localparam int NB  = 24;
  localparam int NS  = 8;
  localparam int LAT = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0, win5_i = 1'b0;
  logic [DW-1:0] centre_i = '0;
  logic [NB*DW-1:0] nbr_i = '0;
  logic valid_o, win5_o;
  logic [DW-1:0] min_o, max_o, med_o;

  always #2 clk = ~clk;

  nbr_sort_median u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .win5_i(win5_i),
    .centre_i(centre_i), .nbr_i(nbr_i), .valid_o(valid_o), .win5_o(win5_o),
    .min_o(min_o), .max_o(max_o), .med_o(med_o)
  );

  int total = 0, bad = 0;
  logic [7:0] q_min[$], q_max[$], q_med[$];
  logic       q_w5[$];
  string      q_tag[$];

  task automatic check(string req, bit ok, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (q_min.size() == 0) begin
        check("R7", 1'b0, "unexpected valid_o", 1, 0);
      end else begin
        automatic logic [7:0] emn = q_min.pop_front();
        automatic logic [7:0] emx = q_max.pop_front();
        automatic logic [7:0] emd = q_med.pop_front();
        automatic logic       ew  = q_w5.pop_front();
        automatic string      t   = q_tag.pop_front();
        check(t, min_o == emn, "min (R1)", min_o, emn);
        check(t, max_o == emx, "max (R2)", max_o, emx);
        check(t, med_o == emd, "median", med_o, emd);
        check(t, win5_o == ew, "size tag (R9)", win5_o, ew);
      end
    end
  end

  task automatic ref_calc(input logic [7:0] nb [NB], input logic [7:0] c,
                          input bit w5, output logic [7:0] mn,
                          output logic [7:0] mx, output logic [7:0] md);
    int a [NB+1];
    int n = w5 ? NB : NS;
    for (int i = 0; i < n; i++) a[i] = nb[i];
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n - 1 - i; j++)
        if (a[j] > a[j+1]) begin int t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
    mn = 8'(a[0]);
    mx = 8'(a[n-1]);
    a[n] = c;
    for (int i = 0; i < n + 1; i++)
      for (int j = 0; j < n - i; j++)
        if (a[j] > a[j+1]) begin int t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
    md = 8'(a[n/2]);
  endtask

  task automatic send(input logic [7:0] nb [NB], input logic [7:0] c,
                      input bit w5, input string tag);
    logic [7:0] mn, mx, md;
    @(negedge clk);
    valid_i  = 1'b1;
    win5_i   = w5;
    centre_i = c;
    for (int k = 0; k < NB; k++) nbr_i[k*DW +: DW] = nb[k];
    ref_calc(nb, c, w5, mn, mx, md);
    q_min.push_back(mn); q_max.push_back(mx); q_med.push_back(md);
    q_w5.push_back(w5);  q_tag.push_back(tag);
  endtask

  task automatic drain(input string req);
    @(negedge clk);
    valid_i = 1'b0;
    for (int i = 0; i < LAT + 4 && q_min.size() != 0; i++) @(negedge clk);
    check(req, q_min.size() == 0, "results outstanding", q_min.size(), 0);
  endtask

  task automatic rand_win(output logic [7:0] nb [NB]);
    for (int k = 0; k < NB; k++) nb[k] = 8'($urandom_range(0, 255));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R8", valid_o == 1'b0, "valid_o in reset", valid_o, 0);
    check("R8", {win5_o, min_o, max_o, med_o} == '0, "outputs in reset",
          {win5_o, min_o, max_o, med_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", valid_o == 1'b0, "valid_o idle after reset", valid_o, 0);
  endtask

  task automatic t_latency();
    logic [7:0] nb [NB];
    int cnt = 0;
    rand_win(nb);
    send(nb, 8'd77, 1'b0, "R7");
    @(posedge clk);
    cnt = 1;
    @(negedge clk);
    valid_i = 1'b0;
    while (!valid_o && cnt < LAT + 10) begin
      @(posedge clk); cnt++;
      @(negedge clk);
    end
    check("R7", cnt == LAT, "latency in cycles", cnt, LAT);
    drain("R7");
  endtask

  task automatic t_small_rand();
    logic [7:0] nb [NB];
    for (int i = 0; i < 20; i++) begin
      rand_win(nb);
      send(nb, 8'($urandom_range(0, 255)), 1'b0, "R4");
    end
    drain("R4");
  endtask

  task automatic t_big_rand();
    logic [7:0] nb [NB];
    for (int i = 0; i < 20; i++) begin
      rand_win(nb);
      send(nb, 8'($urandom_range(0, 255)), 1'b1, "R5");
    end
    drain("R5");
  endtask

  task automatic t_ignore_upper();
    logic [7:0] nb [NB];
    for (int k = 0; k < NS; k++) nb[k] = 8'(20 + 11 * k);
    for (int v = 0; v < 3; v++) begin
      for (int k = NS; k < NB; k++)
        nb[k] = (v == 0) ? 8'd0 : (v == 1) ? 8'($urandom_range(0, 255)) : 8'(k);
      send(nb, 8'd60, 1'b0, "R3");
    end
    drain("R3");
  endtask

  task automatic t_centre_extreme();
    logic [7:0] nb [NB];
    for (int k = 0; k < NB; k++) nb[k] = 8'(100 + k);
    send(nb, 8'd255, 1'b0, "R6");
    send(nb, 8'd0,   1'b0, "R6");
    send(nb, 8'd255, 1'b1, "R6");
    send(nb, 8'd0,   1'b1, "R6");
    drain("R6");
  endtask

  task automatic t_mixed();
    logic [7:0] nb [NB];
    for (int i = 0; i < 16; i++) begin
      rand_win(nb);
      send(nb, 8'($urandom_range(0, 255)), 1'(i % 2), "R9");
    end
    drain("R9");
  endtask

  task automatic t_bounds();
    logic [7:0] nb [NB];
    int vals [3] = '{0, 255, 128};
    for (int v = 0; v < 3; v++)
      for (int w = 0; w < 2; w++) begin
        for (int k = 0; k < NB; k++) nb[k] = 8'(vals[v]);
        send(nb, 8'(vals[v]), 1'(w), "R10");
      end
    for (int k = 0; k < NB; k++) nb[k] = (k % 3 == 0) ? 8'd9 : 8'd200;
    send(nb, 8'd9, 1'b0, "R10");
    send(nb, 8'd200, 1'b1, "R10");
    drain("R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("R7", 1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (2) @(negedge clk);
    t_reset();
    t_latency();
    t_small_rand();
    t_big_rand();
    t_ignore_upper();
    t_centre_extreme();
    t_mixed();
    t_bounds();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule